// File: doc/BRIEF.md
# Variable-Page Translation Buffer

This block is a small fully associative translation buffer for a 32-bit address space. Each slot pairs a tag word (virtual page tag, page-size code, a preserved flag and a valid flag) with a data word (physical page base, byte order, access width and a mixed-attribute flag). Each slot has its own page size of 4 KB, 64 KB, 1 MB or 16 MB. The page size sets how many upper address bits the slot compares, so slots of different sizes can share the buffer.

Lookups arrive on a valid/ready stream. A request is accepted when `lk_valid` and `lk_ready` are both high. Its result is presented one cycle later on a registered valid/ready output. `lk_ready` is high when the output stage is empty or is being drained in the same cycle. If the consumer holds `rs_ready` low, the result stays frozen and new requests wait. A lookup that matches no valid slot, or more than one, reports a fault instead of a translation. It also records the faulting address and raises a status bit.

Software uses a small word-addressed register port with a combinational read. Through it, software fills slots in two writes (tag word, then data word), reads any slot back through the victim index, and moves the victim index and the lock floor. It can also mask and clear fault status and read a revision word. The interrupt line is the OR of the enabled status bits.

Top module: `vtlb_xlate`

## Requirements
- R1: A valid slot matches when the address bits its page-size code covers equal its tag. The page-size code sits in tag-word bits [1:0]. Code 0 (4 KB) compares bits [31:12], 1 (64 KB) compares [31:16], 2 (1 MB) compares [31:20] and 3 (16 MB) compares [31:24].
- R2: On a single match, `rs_paddr` takes the data word's physical base for the bits the page mask covers and the lookup address for the remaining low bits.
- R3: A write to address 6 stages a tag word. Tag word layout: tag [31:12], preserved bit 3, valid bit 2, size [1:0]. A following write to address 7 stores the staged tag word, with bit 2 forced to 1, and the written data word into the slot at the victim index. Reads of address 6 and 7 return the tag word and data word of the slot at the victim index.
- R4: Address 4 holds the lock floor and address 5 holds the victim index; both can be read and written. After each slot load the victim index goes up by one. Past the last slot it returns to the lock floor, so slots below the floor are never replaced by the automatic sequence.
- R5: A lookup that matches no valid slot returns `rs_miss`=1 with `rs_paddr` and `rs_attr` zero. It also sets status bit 0 and copies the address into the fault register at address 3.
- R6: A lookup that matches two or more valid slots returns `rs_multi`=1, never together with `rs_miss`, with zero address and attributes. It also sets status bit 4 and captures the fault address.
- R7: Status (address 1) holds bit 0 miss, bit 1 translation fault, bit 2 emulation miss, bit 3 table-walk fault and bit 4 multi-hit. Writing ones clears those bits, and a hardware set in the same cycle wins. Address 2 is a 5-bit enable, and `irq` is high exactly when an enabled status bit is set.
- R8: Address 0 reads the revision: major version in bits [7:4], minor in [3:0] (default 2.1, giving 0x21).
- R9: A result appears on `rs_valid` the cycle after the request handshake. While `rs_valid` is high and `rs_ready` low, the result stays unchanged and `lk_ready` is low.
- R10: `rs_attr` on a hit is {mixed, size code, byte order}, taken from data-word bits 6, [8:7] and 9. Size code: 0 = 8-bit, 1 = 16-bit, 2 = 32-bit. Byte order: 1 = big endian, 0 = little endian.
- R11: After reset all slots are invalid, and status, enable, lock floor, victim index and `rs_valid` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Lookup request ready |
| lk_vaddr | input | 32 | Lookup virtual address |
| rs_valid | output | 1 | Result valid |
| rs_ready | input | 1 | Result ready |
| rs_paddr | output | 32 | Translated address |
| rs_attr | output | 4 | {mixed, size code, byte order} |
| rs_miss | output | 1 | Result is a no-match fault |
| rs_multi | output | 1 | Result is a multi-match fault |
| irq | output | 1 | Enabled fault status pending |

## Verification
A slot word stored wrongly, or a page mask decoded wrongly, shows on the next lookup that touches it. The one-cycle result then carries a wrong address or attribute, or an unexpected miss or multi-match. A victim index that advances or wraps wrongly shows on the very next read of address 5, or when a later load overwrites a slot below the lock floor, so a later lookup misses. A status, enable or fault-address register out of step shows at once on `irq` and on the next read of addresses 1 to 3.

// File: rtl/vtlb_pkg.sv
package vtlb_pkg;

  typedef enum logic [1:0] {
    PG_4K  = 2'd0,
    PG_64K = 2'd1,
    PG_1M  = 2'd2,
    PG_16M = 2'd3
  } pg_size_e;

  typedef struct packed {
    logic [19:0] tag;
    logic [7:0]  spare;
    logic        preserved;
    logic        valid;
    pg_size_e    size;
  } tag_word_t;

  typedef struct packed {
    logic [19:0] pbase;
    logic [1:0]  spare_hi;
    logic        big_end;
    logic [1:0]  width;
    logic        mixed;
    logic [5:0]  spare_lo;
  } data_word_t;

  // register word addresses
  localparam logic [2:0] A_REV   = 3'd0;
  localparam logic [2:0] A_STAT  = 3'd1;
  localparam logic [2:0] A_EN    = 3'd2;
  localparam logic [2:0] A_FADDR = 3'd3;
  localparam logic [2:0] A_LOCK  = 3'd4;
  localparam logic [2:0] A_VICT  = 3'd5;
  localparam logic [2:0] A_TAGW  = 3'd6;
  localparam logic [2:0] A_DATAW = 3'd7;

  // status bit positions
  localparam int ST_MISS  = 0;
  localparam int ST_XLATE = 1;
  localparam int ST_EMU   = 2;
  localparam int ST_WALK  = 3;
  localparam int ST_MULTI = 4;
  localparam int ST_W     = 5;

  localparam int VALID_BIT = 2;

  function automatic logic [31:0] page_mask(input pg_size_e sz);
    case (sz)
      PG_4K:   page_mask = 32'hFFFF_F000;
      PG_64K:  page_mask = 32'hFFFF_0000;
      PG_1M:   page_mask = 32'hFFF0_0000;
      default: page_mask = 32'hFF00_0000;
    endcase
  endfunction

endpackage

// File: rtl/vtlb_entry_array.sv
module vtlb_entry_array
  import vtlb_pkg::*;
#(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [31:0]   wr_tag,
  input  logic [31:0]   wr_data,
  input  logic [31:0]   look_va,
  input  logic [IW-1:0] rd_idx,
  output logic [31:0]   rd_tag,
  output logic [31:0]   rd_data,
  output logic [N-1:0]  hit_vec,
  output logic [1:0]    sel_size,
  output logic [31:0]   sel_data
);

  logic [31:0] tag_q  [N];
  logic [31:0] data_q [N];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        tag_q[i]  <= '0;
        data_q[i] <= '0;
      end
    end else if (wr_en) begin
      tag_q[wr_idx]  <= wr_tag;
      data_q[wr_idx] <= wr_data;
    end
  end

  // per-slot comparator, each slot masked by its own page size
  for (genvar g = 0; g < N; g++) begin : g_slot
    tag_word_t tw;
    logic [31:0] msk;
    assign tw  = tag_word_t'(tag_q[g]);
    assign msk = page_mask(tw.size);
    assign hit_vec[g] = tw.valid && (((look_va ^ tag_q[g]) & msk) == 32'h0);
  end

  always_comb begin
    sel_size = '0;
    sel_data = '0;
    for (int i = 0; i < N; i++) begin
      if (hit_vec[i]) begin
        sel_size = sel_size | tag_q[i][1:0];
        sel_data = sel_data | data_q[i];
      end
    end
  end

  assign rd_tag  = tag_q[rd_idx];
  assign rd_data = data_q[rd_idx];

endmodule

// File: rtl/vtlb_lookup.sv
module vtlb_lookup
  import vtlb_pkg::*;
#(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         lk_valid,
  output logic         lk_ready,
  input  logic [31:0]  lk_vaddr,
  input  logic [N-1:0] hit_vec,
  input  logic [1:0]   sel_size,
  input  logic [31:0]  sel_data,
  output logic         rs_valid,
  input  logic         rs_ready,
  output logic [31:0]  rs_paddr,
  output logic [3:0]   rs_attr,
  output logic         rs_miss,
  output logic         rs_multi,
  output logic         ev_miss,
  output logic         ev_multi,
  output logic [31:0]  ev_addr
);

  logic [IW:0]  hit_cnt;
  logic         no_hit, many_hit, accept;
  logic [31:0]  msk, pa_c;
  logic [3:0]   attr_c;
  data_word_t   dw;

  always_comb begin
    hit_cnt = '0;
    for (int i = 0; i < N; i++) hit_cnt = hit_cnt + {{IW{1'b0}}, hit_vec[i]};
  end

  assign no_hit   = (hit_cnt == '0);
  assign many_hit = (hit_cnt > 1);
  assign msk      = page_mask(pg_size_e'(sel_size));
  assign pa_c     = (sel_data & msk) | (lk_vaddr & ~msk);
  assign dw       = data_word_t'(sel_data);
  assign attr_c   = {dw.mixed, dw.width, dw.big_end};

  assign lk_ready = !rs_valid || rs_ready;
  assign accept   = lk_valid && lk_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_valid <= 1'b0;
      rs_paddr <= '0;
      rs_attr  <= '0;
      rs_miss  <= 1'b0;
      rs_multi <= 1'b0;
    end else if (accept) begin
      rs_valid <= 1'b1;
      rs_miss  <= no_hit;
      rs_multi <= many_hit;
      rs_paddr <= (no_hit || many_hit) ? 32'h0 : pa_c;
      rs_attr  <= (no_hit || many_hit) ? 4'h0 : attr_c;
    end else if (rs_ready) begin
      rs_valid <= 1'b0;
    end
  end

  assign ev_miss  = accept && no_hit;
  assign ev_multi = accept && many_hit;
  assign ev_addr  = lk_vaddr;

endmodule

// File: rtl/vtlb_regs.sv
module vtlb_regs
  import vtlb_pkg::*;
#(
  parameter int N         = 8,
  parameter int IW        = $clog2(N),
  parameter int REV_MAJOR = 2,
  parameter int REV_MINOR = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_we,
  input  logic [2:0]      reg_addr,
  input  logic [31:0]     reg_wdata,
  output logic [31:0]     reg_rdata,
  input  logic            ev_miss,
  input  logic            ev_multi,
  input  logic [31:0]     ev_addr,
  input  logic [31:0]     rd_tag,
  input  logic [31:0]     rd_data,
  output logic            load_en,
  output logic [31:0]     load_tag,
  output logic [31:0]     load_data,
  output logic [IW-1:0]   victim_q,
  output logic [IW-1:0]   lock_q,
  output logic [ST_W-1:0] stat_q,
  output logic            irq
);

  localparam logic [IW-1:0] LAST = IW'(N - 1);

  logic [31:0]     stage_q, faddr_q;
  logic [ST_W-1:0] en_q, clr, set;
  logic [IW-1:0]   vict_nxt;

  assign load_en   = reg_we && (reg_addr == A_DATAW);
  assign load_tag  = stage_q | (32'h1 << VALID_BIT);
  assign load_data = reg_wdata;
  assign vict_nxt  = (victim_q == LAST) ? lock_q : victim_q + 1'b1;

  always_comb begin
    set = '0;
    set[ST_MISS]  = ev_miss;
    set[ST_MULTI] = ev_multi;
    clr = (reg_we && reg_addr == A_STAT) ? reg_wdata[ST_W-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q  <= '0;
      faddr_q  <= '0;
      en_q     <= '0;
      stat_q   <= '0;
      lock_q   <= '0;
      victim_q <= '0;
    end else begin
      stat_q <= (stat_q & ~clr) | set;
      if (ev_miss || ev_multi) faddr_q <= ev_addr;
      if (reg_we) begin
        case (reg_addr)
          A_EN:    en_q     <= reg_wdata[ST_W-1:0];
          A_LOCK:  lock_q   <= reg_wdata[IW-1:0];
          A_VICT:  victim_q <= reg_wdata[IW-1:0];
          A_TAGW:  stage_q  <= reg_wdata;
          A_DATAW: victim_q <= vict_nxt;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (reg_addr)
      A_REV:   reg_rdata = {24'h0, 4'(REV_MAJOR), 4'(REV_MINOR)};
      A_STAT:  reg_rdata = {{(32-ST_W){1'b0}}, stat_q};
      A_EN:    reg_rdata = {{(32-ST_W){1'b0}}, en_q};
      A_FADDR: reg_rdata = faddr_q;
      A_LOCK:  reg_rdata = {{(32-IW){1'b0}}, lock_q};
      A_VICT:  reg_rdata = {{(32-IW){1'b0}}, victim_q};
      A_TAGW:  reg_rdata = rd_tag;
      default: reg_rdata = rd_data;
    endcase
  end

  assign irq = |(stat_q & en_q);

endmodule

// File: rtl/vtlb_xlate.sv
module vtlb_xlate
  import vtlb_pkg::*;
#(
  parameter int N_ENT     = 8,
  parameter int REV_MAJOR = 2,
  parameter int REV_MINOR = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        lk_valid,
  output logic        lk_ready,
  input  logic [31:0] lk_vaddr,
  output logic        rs_valid,
  input  logic        rs_ready,
  output logic [31:0] rs_paddr,
  output logic [3:0]  rs_attr,
  output logic        rs_miss,
  output logic        rs_multi,
  output logic        irq
);

  localparam int IW = $clog2(N_ENT);

  logic            load_en;
  logic [31:0]     load_tag, load_data, rd_tag, rd_data, sel_data, ev_addr;
  logic [N_ENT-1:0] hit_vec;
  logic [1:0]      sel_size;
  logic            ev_miss, ev_multi;
  logic [IW-1:0]   victim_q, lock_q;
  logic [ST_W-1:0] stat_q;

  vtlb_entry_array #(.N(N_ENT), .IW(IW)) u_arr (
    .clk(clk), .rst_n(rst_n),
    .wr_en(load_en), .wr_idx(victim_q), .wr_tag(load_tag), .wr_data(load_data),
    .look_va(lk_vaddr), .rd_idx(victim_q), .rd_tag(rd_tag), .rd_data(rd_data),
    .hit_vec(hit_vec), .sel_size(sel_size), .sel_data(sel_data)
  );

  vtlb_lookup #(.N(N_ENT), .IW(IW)) u_look (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_vaddr(lk_vaddr),
    .hit_vec(hit_vec), .sel_size(sel_size), .sel_data(sel_data),
    .rs_valid(rs_valid), .rs_ready(rs_ready), .rs_paddr(rs_paddr),
    .rs_attr(rs_attr), .rs_miss(rs_miss), .rs_multi(rs_multi),
    .ev_miss(ev_miss), .ev_multi(ev_multi), .ev_addr(ev_addr)
  );

  vtlb_regs #(.N(N_ENT), .IW(IW), .REV_MAJOR(REV_MAJOR), .REV_MINOR(REV_MINOR)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ev_miss(ev_miss), .ev_multi(ev_multi), .ev_addr(ev_addr),
    .rd_tag(rd_tag), .rd_data(rd_data),
    .load_en(load_en), .load_tag(load_tag), .load_data(load_data),
    .victim_q(victim_q), .lock_q(lock_q), .stat_q(stat_q), .irq(irq)
  );

endmodule

// File: rtl/vtlb_xlate_chk.sv
module vtlb_xlate_chk #(
  parameter int IW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          lk_valid,
  input logic          lk_ready,
  input logic          rs_valid,
  input logic          rs_ready,
  input logic [31:0]   rs_paddr,
  input logic [3:0]    rs_attr,
  input logic          rs_miss,
  input logic          rs_multi,
  input logic          reg_we,
  input logic [2:0]    reg_addr,
  input logic          st_miss,
  input logic          st_multi,
  input logic [IW-1:0] victim,
  input logic [IW-1:0] lockbase
);

  logic acc_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= 1'b0;
    else        acc_q <= lk_valid && lk_ready;
  end

  p_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_ready) |=> rs_valid);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && !rs_ready) |=> (rs_valid && $stable(rs_paddr) && $stable(rs_attr)
                                 && $stable(rs_miss) && $stable(rs_multi)));

  p_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rs_valid |-> !(rs_miss && rs_multi));

  p_fault_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && (rs_miss || rs_multi)) |-> (rs_paddr == 32'h0 && rs_attr == 4'h0));

  p_miss_stat_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_q && rs_miss) |-> st_miss);

  p_multi_stat_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_q && rs_multi) |-> st_multi);

  p_floor_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 3'd7 && victim >= lockbase) |=> (victim >= lockbase));

endmodule

bind vtlb_xlate vtlb_xlate_chk #(.IW(IW)) i_chk (
  .clk(clk), .rst_n(rst_n),
  .lk_valid(lk_valid), .lk_ready(lk_ready),
  .rs_valid(rs_valid), .rs_ready(rs_ready), .rs_paddr(rs_paddr), .rs_attr(rs_attr),
  .rs_miss(rs_miss), .rs_multi(rs_multi),
  .reg_we(reg_we), .reg_addr(reg_addr),
  .st_miss(stat_q[0]), .st_multi(stat_q[4]),
  .victim(victim_q), .lockbase(lock_q)
);

// File: tb/test_vtlb_xlate.sv
module test_vtlb_xlate;

  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = 32'h0;
  logic [31:0] reg_rdata;
  logic        lk_valid = 1'b0;
  logic        lk_ready;
  logic [31:0] lk_vaddr = 32'h0;
  logic        rs_valid;
  logic        rs_ready = 1'b1;
  logic [31:0] rs_paddr;
  logic [3:0]  rs_attr;
  logic        rs_miss, rs_multi, irq;

  int n_run = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  vtlb_xlate i_vtlb_xlate (
    .clk(clk), .rst_n(rst_n),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_vaddr(lk_vaddr),
    .rs_valid(rs_valid), .rs_ready(rs_ready), .rs_paddr(rs_paddr), .rs_attr(rs_attr),
    .rs_miss(rs_miss), .rs_multi(rs_multi), .irq(irq)
  );

  // bench model of the slots
  logic [31:0] m_tag [N];
  logic [31:0] m_dat [N];
  int m_vict = 0;
  int m_lock = 0;

  typedef struct {
    logic        miss;
    logic        multi;
    logic [31:0] pa;
    logic [3:0]  attr;
  } exp_t;

  function automatic logic [31:0] mask_of(input logic [1:0] s);
    case (s)
      2'd0: return 32'hFFFF_F000;
      2'd1: return 32'hFFFF_0000;
      2'd2: return 32'hFFF0_0000;
      default: return 32'hFF00_0000;
    endcase
  endfunction

  function automatic exp_t predict(input logic [31:0] va);
    exp_t e;
    int cnt = 0;
    int idx = 0;
    for (int j = 0; j < N; j++) begin
      if (m_tag[j][2] && (((va ^ m_tag[j]) & mask_of(m_tag[j][1:0])) == 0)) begin
        cnt++;
        idx = j;
      end
    end
    e.miss = (cnt == 0);
    e.multi = (cnt > 1);
    if (cnt == 1) begin
      e.pa = (m_dat[idx] & mask_of(m_tag[idx][1:0])) | (va & ~mask_of(m_tag[idx][1:0]));
      e.attr = {m_dat[idx][6], m_dat[idx][8:7], m_dat[idx][9]};
    end else begin
      e.pa = 32'h0;
      e.attr = 4'h0;
    end
    return e;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic load(input logic [31:0] tw, input logic [31:0] dw);
    wr(3'd6, tw);
    wr(3'd7, dw);
    m_tag[m_vict] = tw | 32'h4;
    m_dat[m_vict] = dw;
    m_vict = (m_vict == N - 1) ? m_lock : m_vict + 1;
  endtask

  task automatic look(input logic [31:0] va, input bit check_regs);
    exp_t e;
    logic [31:0] r;
    e = predict(va);
    @(negedge clk);
    lk_valid = 1'b1; lk_vaddr = va; rs_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    lk_valid = 1'b0;
    chk(rs_valid === 1'b1, "R9 result valid", {31'h0, rs_valid}, 32'h1);
    chk(rs_miss === e.miss, "R5 miss flag", {31'h0, rs_miss}, {31'h0, e.miss});
    chk(rs_multi === e.multi, "R6 multi flag", {31'h0, rs_multi}, {31'h0, e.multi});
    chk(rs_paddr === e.pa, "R1/R2 paddr", rs_paddr, e.pa);
    chk(rs_attr === e.attr, "R10 attr", {28'h0, rs_attr}, {28'h0, e.attr});
    if (check_regs && (e.miss || e.multi)) begin
      rd(3'd3, r);
      chk(r === va, "R5/R6 fault address", r, va);
      rd(3'd1, r);
      chk(r[0] === e.miss && r[4] === e.multi, "R5/R6 status", r, {27'h0, e.multi, 3'b0, e.miss});
      wr(3'd1, 32'h1F);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] r;
    exp_t ea, eb;
    void'($urandom(32'd1234));
    for (int j = 0; j < N; j++) begin m_tag[j] = 0; m_dat[j] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R11 reset state
    @(negedge clk);
    chk(rs_valid === 1'b0 && irq === 1'b0, "R11 outputs idle", {30'h0, rs_valid, irq}, 32'h0);
    rd(3'd1, r); chk(r === 0, "R11 status", r, 0);
    rd(3'd2, r); chk(r === 0, "R11 enable", r, 0);
    rd(3'd4, r); chk(r === 0, "R11 lock", r, 0);
    rd(3'd5, r); chk(r === 0, "R11 victim", r, 0);
    look(32'h1234_5678, 1'b1);

    // R8 revision
    rd(3'd0, r); chk(r === 32'h21, "R8 revision", r, 32'h21);

    // directed table: multi-hit pair, mixed sizes
    load(32'h1234_5000 | 32'd0, 32'hABCD_E000 | 32'h2C0);
    load(32'h1230_0000 | 32'd2, 32'h5550_0000 | 32'h200);
    load(32'h4000_0000 | 32'd1, 32'h7777_0000 | 32'h140);
    load(32'h8000_0000 | 32'd3 | 32'h8, 32'hC100_0000 | 32'h100);
    for (int j = 4; j < N; j++) load(32'h0000_1000 * j, 32'h0900_0000 + 32'h1000 * j);
    look(32'h1234_5678, 1'b1);   // R6 two slots
    look(32'h1239_9ABC, 1'b1);   // R1 1 MB hit
    look(32'h4000_FFFC, 1'b1);   // R1 64 KB upper edge
    look(32'h4001_0000, 1'b1);   // R1 just past 64 KB
    look(32'h80FF_FFFF, 1'b1);   // R1 16 MB upper edge
    look(32'h8100_0000, 1'b1);   // R5 just past 16 MB
    look(32'h0000_5FFF, 1'b1);   // R2 4 KB slot

    // R3 readback by victim index
    wr(3'd5, 32'd3); m_vict = 3;
    rd(3'd6, r); chk(r === m_tag[3] && r[2] === 1'b1, "R3 tag readback", r, m_tag[3]);
    rd(3'd7, r); chk(r === m_dat[3], "R3 data readback", r, m_dat[3]);

    // R4 wrap to lock floor
    wr(3'd4, 32'd5); m_lock = 5;
    rd(3'd4, r); chk(r === 5, "R4 lock readback", r, 5);
    wr(3'd5, 32'd7); m_vict = 7;
    load(32'h0000_7000, 32'h0A00_7000);
    rd(3'd5, r); chk(r === 5, "R4 wrap to floor", r, 5);
    load(32'h0000_5000, 32'h0B00_5000);
    rd(3'd5, r); chk(r === 6, "R4 advance", r, 6);
    look(32'h0000_7123, 1'b1);
    look(32'h1239_9000, 1'b1);   // slot 1 below floor survives

    // R7 enable, irq, write-one-to-clear, masking
    wr(3'd2, 32'h01);
    rd(3'd2, r); chk(r === 1, "R7 enable readback", r, 1);
    look(32'hDEAD_0000, 1'b0);
    @(negedge clk); chk(irq === 1'b1, "R7 irq on enabled miss", {31'h0, irq}, 1);
    wr(3'd1, 32'h01);
    chk(irq === 1'b0, "R7 irq after clear", {31'h0, irq}, 0);
    rd(3'd1, r); chk(r === 0, "R7 status cleared", r, 0);
    look(32'h1234_5000, 1'b0);   // multi-hit, bit 4 not enabled
    @(negedge clk); chk(irq === 1'b0, "R7 masked multi", {31'h0, irq}, 0);
    wr(3'd1, 32'h1F);

    // R9 back-pressure
    ea = predict(32'h4000_1234);
    eb = predict(32'h0000_6010);
    @(negedge clk);
    rs_ready = 1'b0; lk_valid = 1'b1; lk_vaddr = 32'h4000_1234;
    @(posedge clk);
    @(negedge clk);
    lk_vaddr = 32'h0000_6010;
    for (int k = 0; k < 3; k++) begin
      chk(lk_ready === 1'b0, "R9 ready low while stalled", {31'h0, lk_ready}, 0);
      chk(rs_valid === 1'b1 && rs_paddr === ea.pa, "R9 held result", rs_paddr, ea.pa);
      @(negedge clk);
    end
    rs_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    lk_valid = 1'b0;
    chk(rs_valid === 1'b1 && rs_paddr === eb.pa, "R9 next result", rs_paddr, eb.pa);
    chk(rs_attr === eb.attr, "R10 next attr", {28'h0, rs_attr}, {28'h0, eb.attr});

    // random section
    wr(3'd4, 32'd0); m_lock = 0;
    wr(3'd5, 32'd0); m_vict = 0;
    for (int j = 0; j < N; j++) begin
      logic [31:0] t;
      t = $urandom & 32'hFFFF_F00B;
      load(t, $urandom);
    end
    for (int k = 0; k < 300; k++) begin
      logic [31:0] va;
      int j;
      j = int'($urandom_range(N - 1, 0));
      if ($urandom_range(3, 0) != 0)
        va = (m_tag[j] & mask_of(m_tag[j][1:0])) | ($urandom & ~mask_of(m_tag[j][1:0]));
      else
        va = $urandom;
      look(va, 1'b1);
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule